// File: doc/BRIEF.md
# Scanline Timing Interrupt Generator

This block turns a line counter into the per-line interrupt requests of a display system. Each time a new line begins, a `line_start` strobe arrives with the line number. The block then decides which timing sources fire on that line. The line sources are vertical-blank-out, vertical-blank-in, horizontal-blank-in, a line-compare timer, a per-line timer and sprite-draw-end. A sound request input forms a seventh source, which fires in any cycle.

Every source has its own enable bit. A source that fires while enabled does two things. It sets a pending interrupt that carries a fixed priority level and a fixed vector. It also emits a one-cycle DMA start event whose code is the bit position on `dma_evt`. The pending requests are presented one at a time, highest level first. A presented request stays up until `irq_ack` clears it.

Top module: `scanline_irq_gen`

## Requirements
- R1: After reset, `irq_req` is 0, `irq_level` is 0, `irq_vector` is 0 and `dma_evt` is all zero.
- R2: With `src_en[1]` set, `line_start` on line 0 fires vertical-blank-out. It requests level 14 with vector 0x41 and DMA code 1.
- R3: With `src_en[0]` set, `line_start` on the line equal to `blank_line` fires vertical-blank-in. It requests level 15 with vector 0x40 and DMA code 0. On that same line, if `draw_done` is high and `src_en[6]` is set, sprite-draw-end fires. It requests level 2 with vector 0x4D and DMA code 6.
- R4: With `src_en[2]` set, horizontal-blank-in fires on every line that is greater than 0 and below `blank_line`. It requests level 13 with vector 0x42 and DMA code 2. It does not fire on line 0, and it does not fire on any line at or beyond `blank_line`.
- R5: With `src_en[3]` set, timer 0 fires when the line equals `tmr0_cmp`, where `tmr0_cmp` is 10 bits wide. It requests level 12 with vector 0x43 and DMA code 3.
- R6: With `src_en[4]` set, timer 1 fires on every `line_start` for which `tmr1_ctrl[0]` is 1 and `tmr1_ctrl[7]` is 0. It requests level 11 with vector 0x44 and DMA code 4.
- R7: With `src_en[5]` set, `snd_req` fires the sound source in any cycle, whether or not a `line_start` arrives. It requests level 9 with vector 0x46 and DMA code 5.
- R8: A source whose enable bit is clear sets no request and raises no `dma_evt` bit, even when its condition is met.
- R9: When several requests are pending, `irq_level` and `irq_vector` show the one with the highest level. When `irq_ack` is high, it clears only that presented request, and the next highest one then appears.
- R10: A pending request stays pending until it is acknowledged. If a source fires in the same cycle that its request is acknowledged, the request stays set.
- R11: `dma_evt[k]` is high for exactly the one cycle after the edge that samples a firing of the source with code k. `irq_req` rises only together with at least one `dma_evt` bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_start | input | 1 | Start-of-line strobe, qualifies `line_num` |
| line_num | input | LW | Current line number |
| blank_line | input | LW | First line of vertical blank |
| tmr0_cmp | input | LW | Line-compare value for timer 0 |
| tmr1_ctrl | input | 8 | Timer 1 control; bit 0 run, bit 7 inhibit |
| src_en | input | 7 | Per-source enable, bit index equals DMA code |
| draw_done | input | 1 | Sprite drawing finished flag |
| snd_req | input | 1 | Sound interrupt request strobe |
| irq_ack | input | 1 | Clears the presented request |
| irq_req | output | 1 | Any request pending |
| irq_level | output | 4 | Level of the presented request, 0 when idle |
| irq_vector | output | 8 | Vector of the presented request, 0 when idle |
| dma_evt | output | 7 | One-cycle DMA start events, bit k is code k |

## Verification
The hardest case to reach is a single line on which four or five sources fire together while older requests are still pending and an acknowledge lands in that same cycle. Uncoordinated random values would almost never produce it. To make it likely, the random stimulus draws most line numbers from a small set of interesting values: 0, the blank line, the compare value and their neighbours. It also sets the compare value equal to the blank line at times, and it only sometimes acknowledges, so that the pending set grows deep. A bench model, built on a level table, tracks the pending set and checks both the presentation order and whether each request survives the acknowledge.

// File: rtl/scanline_irq_gen.sv
module scanline_irq_gen #(
  parameter int LW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_start,
  input  logic [LW-1:0] line_num,
  input  logic [LW-1:0] blank_line,
  input  logic [LW-1:0] tmr0_cmp,
  input  logic [7:0]    tmr1_ctrl,
  input  logic [6:0]    src_en,
  input  logic          draw_done,
  input  logic          snd_req,
  input  logic          irq_ack,
  output logic          irq_req,
  output logic [3:0]    irq_level,
  output logic [7:0]    irq_vector,
  output logic [6:0]    dma_evt
);

  localparam int NSRC = 7;

  logic [NSRC-1:0] pend, cond, fire, clr;
  logic [2:0]      sel;
  logic            at_blank;

  assign at_blank = line_num == blank_line;

  // bit order = DMA code; also descending level order
  assign cond[0] = line_start && at_blank;
  assign cond[1] = line_start && line_num == '0;
  assign cond[2] = line_start && line_num != '0 && line_num < blank_line;
  assign cond[3] = line_start && line_num == tmr0_cmp;
  assign cond[4] = line_start && tmr1_ctrl[0] && !tmr1_ctrl[7];
  assign cond[5] = snd_req;
  assign cond[6] = line_start && at_blank && draw_done;
  assign fire    = cond & src_en;

  always_comb begin
    sel = 3'd0;
    for (int k = NSRC - 1; k >= 0; k--)
      if (pend[k]) sel = 3'(k);
  end

  always_comb begin
    clr = '0;
    if (irq_ack && irq_req) clr[sel] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend    <= '0;
      dma_evt <= '0;
    end else begin
      pend    <= (pend & ~clr) | fire;
      dma_evt <= fire;
    end
  end

  assign irq_req = |pend;

  always_comb begin
    irq_level  = 4'd0;
    irq_vector = 8'h00;
    if (irq_req) begin
      case (sel)
        3'd0:    begin irq_level = 4'd15; irq_vector = 8'h40; end
        3'd1:    begin irq_level = 4'd14; irq_vector = 8'h41; end
        3'd2:    begin irq_level = 4'd13; irq_vector = 8'h42; end
        3'd3:    begin irq_level = 4'd12; irq_vector = 8'h43; end
        3'd4:    begin irq_level = 4'd11; irq_vector = 8'h44; end
        3'd5:    begin irq_level = 4'd9;  irq_vector = 8'h46; end
        default: begin irq_level = 4'd2;  irq_vector = 8'h4D; end
      endcase
    end
  end

  p_evt_needs_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((dma_evt & ~$past(src_en)) == '0));

  p_held_until_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !irq_ack) |=> irq_req);

  p_rise_with_event_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) |-> (dma_evt != '0));

  p_level_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_level != 4'd0 && irq_vector[7:4] == 4'h4));

  p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_req |-> (irq_level == 4'd0 && irq_vector == 8'h00));

endmodule

// File: tb/scanline_irq_gen_tb_top.sv
module scanline_irq_gen_tb_top;
  localparam int LW = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          line_start = 1'b0;
  logic [LW-1:0] line_num = '0;
  logic [LW-1:0] blank_line = 10'd224;
  logic [LW-1:0] tmr0_cmp = 10'd100;
  logic [7:0]    tmr1_ctrl = 8'h00;
  logic [6:0]    src_en = '0;
  logic          draw_done = 1'b0;
  logic          snd_req = 1'b0;
  logic          irq_ack = 1'b0;
  logic          irq_req;
  logic [3:0]    irq_level;
  logic [7:0]    irq_vector;
  logic [6:0]    dma_evt;

  int n_cmp = 0, n_bad = 0;
  logic [6:0] m_pend = '0;
  logic [6:0] m_evt = '0;

  always #2 clk = ~clk;

  scanline_irq_gen #(.LW(LW)) dut_i (.*);

  function automatic logic [3:0] lvl_of(int k);
    case (k)
      0: return 4'd15; 1: return 4'd14; 2: return 4'd13; 3: return 4'd12;
      4: return 4'd11; 5: return 4'd9;  default: return 4'd2;
    endcase
  endfunction

  function automatic logic [7:0] vec_of(int k);
    case (k)
      0: return 8'h40; 1: return 8'h41; 2: return 8'h42; 3: return 8'h43;
      4: return 8'h44; 5: return 8'h46; default: return 8'h4D;
    endcase
  endfunction

  function automatic int top_of(logic [6:0] p);
    int best = -1;
    for (int k = 0; k < 7; k++)
      if (p[k] && (best < 0 || lvl_of(k) > lvl_of(best))) best = k;
    return best;
  endfunction

  function automatic logic [6:0] fires_of();
    logic [6:0] f = '0;
    if (line_start) begin
      f[1] = line_num == 0;
      f[0] = line_num == blank_line;
      f[6] = line_num == blank_line && draw_done;
      f[2] = line_num > 0 && line_num < blank_line;
      f[3] = line_num == tmr0_cmp;
      f[4] = tmr1_ctrl[0] && !tmr1_ctrl[7];
    end
    f[5] = snd_req;
    return f & src_en;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp, string what);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // inputs already set (at negedge); advance one edge and compare at next negedge
  task automatic step(string tag);
    logic [6:0] f;
    int t;
    f = fires_of();
    t = top_of(m_pend);
    if (irq_ack && t >= 0) m_pend[t] = 1'b0;
    m_pend = m_pend | f;
    m_evt = f;
    @(negedge clk);
    t = top_of(m_pend);
    chk(tag, 32'(dma_evt), 32'(m_evt), "dma_evt");
    chk(tag, 32'(irq_req), 32'(m_pend != 0), "irq_req");
    chk(tag, 32'(irq_level), (t < 0) ? 32'd0 : 32'(lvl_of(t)), "irq_level");
    chk(tag, 32'(irq_vector), (t < 0) ? 32'd0 : 32'(vec_of(t)), "irq_vector");
    line_start = 1'b0; snd_req = 1'b0; irq_ack = 1'b0;
  endtask

  task automatic line(int n, string tag);
    line_num = LW'(n); line_start = 1'b1;
    step(tag);
  endtask

  task automatic drain(string tag);
    for (int i = 0; i < 8; i++) begin irq_ack = 1'b1; step(tag); end
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1", 32'(irq_req), 0, "irq_req"); chk("R1", 32'(dma_evt), 0, "dma_evt");
    chk("R1", 32'(irq_level), 0, "irq_level"); chk("R1", 32'(irq_vector), 0, "irq_vector");
    rst_n = 1'b1;

    src_en = 7'h7F;
    line(0, "R2"); drain("R2");
    draw_done = 1'b1; line(224, "R3"); drain("R3");
    draw_done = 1'b0; line(224, "R3"); drain("R3");
    line(1, "R4"); line(223, "R4"); drain("R4");
    line(225, "R4"); line(0, "R4"); drain("R4");
    tmr0_cmp = 10'd1023; line(1023, "R5"); drain("R5");
    tmr1_ctrl = 8'h01; line(300, "R6"); drain("R6");
    tmr1_ctrl = 8'h81; line(300, "R6"); drain("R6");
    tmr1_ctrl = 8'h00; snd_req = 1'b1; step("R7"); drain("R7");
    src_en = 7'h00; draw_done = 1'b1; tmr1_ctrl = 8'h01; tmr0_cmp = 10'd224;
    line(224, "R8"); snd_req = 1'b1; line(0, "R8"); drain("R8");
    src_en = 7'h7F; line(224, "R9"); snd_req = 1'b1; step("R9");
    irq_ack = 1'b1; step("R9"); irq_ack = 1'b1; step("R9");
    step("R10"); step("R10");
    irq_ack = 1'b1; line(224, "R10"); drain("R10");
    snd_req = 1'b1; step("R11"); step("R11"); drain("R11");
    draw_done = 1'b0; tmr1_ctrl = 8'h00;

    for (int it = 0; it < 20000; it++) begin
      int r;
      if (it % 500 == 0) begin
        blank_line = LW'(180 + $urandom_range(0, 80));
        tmr0_cmp = ($urandom_range(0, 3) == 0) ? blank_line : LW'($urandom_range(0, 300));
        src_en = ($urandom_range(0, 3) == 0) ? 7'($urandom) : 7'h7F;
      end
      r = $urandom_range(0, 7);
      case (r)
        0: line_num = '0;
        1: line_num = blank_line;
        2: line_num = tmr0_cmp;
        3: line_num = blank_line - 1'b1;
        4: line_num = blank_line + 1'b1;
        default: line_num = LW'($urandom_range(0, 1023));
      endcase
      line_start = $urandom_range(0, 2) != 0;
      tmr1_ctrl = 8'($urandom);
      draw_done = $urandom_range(0, 1) == 1;
      snd_req = $urandom_range(0, 4) == 0;
      irq_ack = $urandom_range(0, 2) == 0;
      step("R9");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule